// File: doc/BRIEF.md
# RTC Interrupt Flag and Alarm Controller

This block is the interrupt section of a real-time clock. It keeps three sticky event flags: periodic, alarm and update-ended. Each flag is set by its event whatever the enable bits say. A set of enable bits only decides whether a flag may pull the active-low interrupt line. A summary bit reports whether any enabled flag is pending.

The block holds a control register with the enables and two stored format bits, and a read-only status register with the flags. It also holds three alarm bytes. On each once-per-second strobe it compares the alarm bytes with the current hours, minutes and seconds bytes. An alarm byte whose top two bits are both 1 matches any value. Software reads the status register to find the cause of an interrupt, and that read clears every flag at once.

The divider chain, the time counters and the BCD/binary arithmetic sit outside this block. The data-mode and 24-hour bits are only stored here and driven out to those parts.

Top module: `rtc_irq_ctl`

## Requirements
- R1: A `per_tick` pulse sets the periodic flag (status bit 6) whether or not the periodic enable (control bit 6) is set. The enable only decides whether that flag affects the interrupt.
- R2: On a `sec_tick` pulse, the alarm flag (status bit 5) is set when the seconds, minutes and hours bytes each match their alarm byte. Alarm bytes live at address 0 (seconds), 1 (minutes) and 2 (hours). A `sec_tick` with any mismatch leaves the flag unchanged.
- R3: An alarm byte whose bits 7:6 are 2'b11 matches any value of its time byte.
- R4: An `upd_done` pulse sets the update flag (status bit 4).
- R5: The summary bit (status bit 7) is 1 and `irq_n` is low exactly when one of these holds: periodic flag with periodic enable, alarm flag with alarm enable (control bit 5), or update flag with update enable (control bit 4).
- R6: The status register is at address 4. Its bits 3:0 always read 0, and writes to it change nothing.
- R7: A read of address 4 (`rd_en` high) returns the flags as they were before the read, and clears all three flags on the next clock edge.
- R8: A flag event in the same cycle as a status read stays set after the read.
- R9: Reset (`rst_n` low) clears all flags and the periodic, alarm and update enables.
- R10: A write to the control register (address 3) that takes SET (bit 7) from 0 to 1 clears the update enable, whatever the written bit 4.
- R11: Data mode (control bit 2, 1 = binary) and 24-hour mode (control bit 1, 1 = 24 h) are read/write, appear on `bin_mode` and `hr24`, and keep their value through reset. Control bits 3 and 0 always read 0.
- R12: The alarm bytes at addresses 0 to 2 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| per_tick | input | 1 | One-cycle pulse at the periodic rate |
| upd_done | input | 1 | One-cycle pulse at the end of each update |
| sec_tick | input | 1 | One-cycle once-per-second strobe for the alarm compare |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq_n | output | 1 | Active-low interrupt request |
| set_mode | output | 1 | SET control bit |
| bin_mode | output | 1 | Data mode, 1 = binary |
| hr24 | output | 1 | Hour format, 1 = 24-hour |

## Verification
The assertions take three things for granted about the inputs:
- the event inputs are single-cycle pulses;
- the time bytes are stable while `sec_tick` is high;
- `rd_en` and `wr_en` are never high together on the same address.

The bench keeps to these rules. It drives every input for a whole cycle from the falling edge, pulses events at random and never raises both strobes at once.

Alarm bytes are often written with the wildcard prefix, and time bytes are drawn from a small set of values, so that matches happen often. Reads of the status register are made to coincide with events in the random phase and in a directed test.

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          per_tick,
  input  logic          upd_done,
  input  logic          sec_tick,
  input  logic [7:0]    cur_sec,
  input  logic [7:0]    cur_min,
  input  logic [7:0]    cur_hr,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq_n,
  output logic          set_mode,
  output logic          bin_mode,
  output logic          hr24
);
  localparam logic [AW-1:0] A_ASEC = AW'(0);
  localparam logic [AW-1:0] A_AMIN = AW'(1);
  localparam logic [AW-1:0] A_AHR  = AW'(2);
  localparam logic [AW-1:0] A_CTRL = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);

  logic [7:0] al_sec, al_min, al_hr;
  logic set_q, pie_q, aie_q, uie_q, dm_q, h24_q;
  logic pf_q, af_q, uf_q;
  logic irqf, clr, hit, ctrl_wr;

  function automatic logic byte_hit(input logic [7:0] al, input logic [7:0] t);
    return (al[7:6] == 2'b11) || (al == t);
  endfunction

  assign hit     = sec_tick && byte_hit(al_sec, cur_sec) && byte_hit(al_min, cur_min) && byte_hit(al_hr, cur_hr);
  assign clr     = rd_en && addr == A_STAT;
  assign ctrl_wr = wr_en && addr == A_CTRL;
  assign irqf    = (pf_q && pie_q) || (af_q && aie_q) || (uf_q && uie_q);
  assign irq_n   = ~irqf;
  assign set_mode = set_q;
  assign bin_mode = dm_q;
  assign hr24     = h24_q;

  always_comb begin
    case (addr)
      A_ASEC:  rdata = al_sec;
      A_AMIN:  rdata = al_min;
      A_AHR:   rdata = al_hr;
      A_CTRL:  rdata = {set_q, pie_q, aie_q, uie_q, 1'b0, dm_q, h24_q, 1'b0};
      A_STAT:  rdata = {irqf, pf_q, af_q, uf_q, 4'b0000};
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_sec <= '0;
      al_min <= '0;
      al_hr  <= '0;
      set_q  <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_ASEC) al_sec <= wdata;
      if (addr == A_AMIN) al_min <= wdata;
      if (addr == A_AHR)  al_hr  <= wdata;
      if (addr == A_CTRL) set_q  <= wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pie_q <= 1'b0;
      aie_q <= 1'b0;
      uie_q <= 1'b0;
    end else if (ctrl_wr) begin
      pie_q <= wdata[6];
      aie_q <= wdata[5];
      uie_q <= wdata[4] && !(wdata[7] && !set_q);
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl_wr) begin
      dm_q  <= wdata[2];
      h24_q <= wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
      af_q <= 1'b0;
      uf_q <= 1'b0;
    end else begin
      pf_q <= (pf_q && !clr) || per_tick;
      af_q <= (af_q && !clr) || hit;
      uf_q <= (uf_q && !clr) || upd_done;
    end
  end

  p_per_sets_r1: assert property (@(posedge clk) disable iff (!rst_n) per_tick |=> pf_q);
  p_alarm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && al_sec == cur_sec && al_min == cur_min && al_hr == cur_hr) |=> af_q);
  p_wild_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && al_sec[7:6] == 2'b11 && al_min[7:6] == 2'b11 && al_hr[7:6] == 2'b11) |=> af_q);
  p_upd_sets_r4: assert property (@(posedge clk) disable iff (!rst_n) upd_done |=> uf_q);
  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n) !irq_n |-> (pf_q || af_q || uf_q));
  p_stat_low_r6: assert property (@(posedge clk) disable iff (!rst_n) (addr == A_STAT) |-> rdata[3:0] == 4'h0);
  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !per_tick && !upd_done && !sec_tick) |=> !(pf_q || af_q || uf_q));
  p_set_uie_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[7] && !set_q) |=> !uie_q);
  p_dm_hold_r11: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_wr |=> $stable(dm_q) && $stable(h24_q));
endmodule

// File: tb/rtc_irq_ctl_test.sv
module rtc_irq_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 0, rst_n = 0;
  logic per_tick = 0, upd_done = 0, sec_tick = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hr = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq_n, set_mode, bin_mode, hr24;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  logic m_pf, m_af, m_uf, m_set, m_pie, m_aie, m_uie, m_dm, m_h24;
  logic [7:0] m_al [3];

  rtc_irq_ctl uut (.clk(clk), .rst_n(rst_n), .per_tick(per_tick), .upd_done(upd_done),
    .sec_tick(sec_tick), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .irq_n(irq_n), .set_mode(set_mode), .bin_mode(bin_mode), .hr24(hr24));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic f_hit(input logic [7:0] al, input logic [7:0] t);
    return (al[7:6] == 2'b11) || (al == t);
  endfunction
  function automatic logic f_irq();
    return (m_pf && m_pie) || (m_af && m_aie) || (m_uf && m_uie);
  endfunction
  function automatic logic [7:0] f_reg(input logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd2: return m_al[a];
      3'd3: return {m_set, m_pie, m_aie, m_uie, 1'b0, m_dm, m_h24, 1'b0};
      3'd4: return {f_irq(), m_pf, m_af, m_uf, 4'h0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pf = 0; m_af = 0; m_uf = 0; m_set = 0; m_pie = 0; m_aie = 0; m_uie = 0;
    for (int i = 0; i < 3; i++) m_al[i] = 8'h00;
  endtask

  // one clock: inputs already driven; check, clock, update model
  task automatic step(input string req);
    logic hit, clr;
    #1;
    chk({req, " irq_n"}, {7'b0, irq_n}, {7'b0, ~f_irq()});
    if (rd_en) chk({req, " rdata"}, rdata, f_reg(addr));
    hit = sec_tick && f_hit(m_al[0], cur_sec) && f_hit(m_al[1], cur_min) && f_hit(m_al[2], cur_hr);
    clr = rd_en && addr == 3'd4;
    @(posedge clk);
    m_pf = (m_pf && !clr) || per_tick;
    m_af = (m_af && !clr) || hit;
    m_uf = (m_uf && !clr) || upd_done;
    if (wr_en && addr <= 3'd2) m_al[addr] = wdata;
    if (wr_en && addr == 3'd3) begin
      m_uie = wdata[4] && !(wdata[7] && !m_set);
      m_set = wdata[7]; m_pie = wdata[6]; m_aie = wdata[5];
      m_dm = wdata[2]; m_h24 = wdata[1];
    end
    @(negedge clk);
    per_tick = 0; upd_done = 0; sec_tick = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; step("write");
  endtask
  task automatic rd(input string req, input logic [2:0] a);
    addr = a; rd_en = 1; step(req);
  endtask
  task automatic do_reset();
    rst_n = 0; model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1; @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    model_reset();
    m_dm = 0; m_h24 = 0;
    do_reset();
    wr(3, 8'h00);
    // R9: reset state
    rd("R9 reset status", 4);
    rd("R9 reset ctrl", 3);

    // R1: flag sets with enable off, no irq
    per_tick = 1; step("R1 tick");
    rd("R1 flag no enable", 4);
    chk("R1 irq_n high", {7'b0, irq_n}, 8'h01);
    wr(3, 8'h40);
    rd("R1 R5 enabled irq", 4);   // read clears
    rd("R7 cleared", 4);

    // R12 / R2: exact alarm
    wr(0, 8'h15); wr(1, 8'h30); wr(2, 8'h07);
    rd("R12 asec", 0); rd("R12 amin", 1); rd("R12 ahr", 2);
    wr(3, 8'h20);
    cur_sec = 8'h15; cur_min = 8'h30; cur_hr = 8'h08; sec_tick = 1; step("R2 mismatch");
    rd("R2 no alarm", 4);
    cur_hr = 8'h07; sec_tick = 1; step("R2 match");
    chk("R5 alarm irq", {7'b0, irq_n}, 8'h00);
    rd("R2 R5 alarm flag", 4);
    // R3 wildcard
    wr(2, 8'hC0); cur_hr = 8'h23; sec_tick = 1; step("R3 wild");
    rd("R3 wildcard", 4);

    // R4 update, R10 set clears uie
    wr(3, 8'h10); upd_done = 1; step("R4 upd");
    rd("R4 R5 update", 4);
    wr(3, 8'h90); rd("R10 uie cleared", 3);
    wr(3, 8'h90); rd("R10 set held", 3);

    // R8: event coincides with read
    wr(3, 8'h70);
    per_tick = 1; step("R8 arm");
    addr = 4; rd_en = 1; upd_done = 1; step("R8 read+event");
    rd("R8 event kept", 4);

    // R6 write ignored
    wr(4, 8'hFF); rd("R6 write ignored", 4);

    // R11 format bits survive reset
    wr(3, 8'h0F); rd("R11 ctrl", 3);
    chk("R11 bin_mode", {7'b0, bin_mode}, 8'h01);
    chk("R11 hr24", {7'b0, hr24}, 8'h01);
    per_tick = 1; step("R9 pre");
    do_reset();
    rd("R9 R11 ctrl after reset", 3);
    rd("R9 flags after reset", 4);
    chk("R11 bin after reset", {7'b0, bin_mode}, 8'h01);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      per_tick = ($urandom_range(0, 5) == 0);
      upd_done = ($urandom_range(0, 7) == 0);
      sec_tick = ($urandom_range(0, 3) == 0);
      cur_sec = 8'($urandom_range(0, 2)); cur_min = 8'($urandom_range(0, 2));
      cur_hr = 8'($urandom_range(0, 2));
      if (op < 3) begin
        addr = 3'($urandom_range(0, 3));
        wdata = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 2)) : (8'hC0 | 8'($urandom_range(0, 63)));
        if (addr == 3) wdata = 8'($urandom_range(0, 255));
        wr_en = 1;
      end else if (op < 7) begin
        addr = (op < 6) ? 3'd4 : 3'($urandom_range(0, 7));
        rd_en = 1;
      end
      step((op < 7 && addr == 3'd4) ? "R5 R7 random status" : "R12 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule